// File: doc/BRIEF.md
# Protected SMBASE Window Lock Controller

This block owns a single byte-wide control register that guards a fixed stretch of RAM used as the save-state area of system-management mode. Firmware discovers the protection through a handshake: it writes a query marker, the block answers with a capability code and from then on accepts only one lock bit. Writing that bit seals the window until reset. Every other write, before the query or after the lock, has no lasting effect.

A second, purely combinational path classifies memory accesses. When the window is locked, an access from outside management mode that falls inside the window is marked for the blackhole path (reads return all-ones, writes are dropped). An access made in management mode is marked for the RAM path. While unlocked, or outside the window, neither mark is raised. A static parameter removes the feature entirely.

The controller is a three-state machine. IDLE (reset, full write mask): a write of the query marker takes the transition IDLE to OFFERED; any other write is discarded and the register stays 0x00. OFFERED (mask holds only the lock bit): a write with the lock bit set takes the transition OFFERED to LOCKED; otherwise it stays in OFFERED. LOCKED (empty mask): no transition leaves it except reset.

Top module: `smbase_lock_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and neither route output is asserted.
- R2: In IDLE, a write of any value other than 0xFF (including 0x02) leaves the register reading 0x00 and does not lock.
- R3: In IDLE, a write of 0xFF makes the register read the capability code 0x01 from the next cycle.
- R4: In OFFERED, a write with bit 1 clear leaves the register reading 0x01; all other written bits are ignored.
- R5: In OFFERED, a write with bit 1 set makes the register read exactly 0x02 (locked) from the next cycle.
- R6: In LOCKED, every write, including 0xFF and 0x00, is ignored; the register reads 0x02 until reset.
- R7: In LOCKED, an access with the management flag low and address in [0x30000, 0x4FFFF] raises the blackhole route and not the RAM route.
- R8: In LOCKED, an access with the management flag high in that range raises the RAM route and not the blackhole route.
- R9: Outside the range, or in IDLE or OFFERED, both route outputs are low.
- R10: With the feature parameter off, the register always reads 0x00 and both route outputs stay low whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write byte |
| reg_rd_data | output | 8 | Current register value |
| acc_addr | input | ADDR_W | Address of the access being routed |
| acc_smm | input | 1 | Access is made in management mode |
| route_blackhole | output | 1 | Access goes to the all-ones / drop path |
| route_smram | output | 1 | Access goes to protected RAM |

## Verification
The bench builds two instances side by side from the same stimulus: one with the feature enabled at default window base and size, and one with the feature parameter off. The first reaches every state and transition, both window edges and the addresses just outside them; the second shows the same write sequence leaving the register and routes inert. A behavioural value-and-mask model predicts both instances on every clock.

// File: rtl/smbase_lock_pkg.sv
package smbase_lock_pkg;
    typedef enum logic [1:0] {
        LK_IDLE    = 2'd0,
        LK_OFFERED = 2'd1,
        LK_LOCKED  = 2'd2
    } lk_state_e;

    localparam logic [7:0] QUERY_CODE  = 8'hFF;
    localparam logic [7:0] ANSWER_CODE = 8'h01;
    localparam logic [7:0] LOCK_CODE   = 8'h02;
endpackage

// File: rtl/smbase_lock_fsm.sv
module smbase_lock_fsm
    import smbase_lock_pkg::*;
#(
    parameter logic [7:0] QUERY  = QUERY_CODE,
    parameter logic [7:0] ANSWER = ANSWER_CODE,
    parameter logic [7:0] LOCK   = LOCK_CODE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       locked
);
    lk_state_e state_q, state_d;
    logic      lock_hit;

    assign lock_hit = |(wr_data & LOCK);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE:    if (wr_en && wr_data == QUERY) state_d = LK_OFFERED;
            LK_OFFERED: if (wr_en && lock_hit)         state_d = LK_LOCKED;
            LK_LOCKED:  state_d = LK_LOCKED;
            default:    state_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_data = 8'h00;
        locked  = 1'b0;
        unique case (state_q)
            LK_IDLE:    rd_data = 8'h00;
            LK_OFFERED: rd_data = ANSWER;
            LK_LOCKED: begin
                rd_data = LOCK;
                locked  = 1'b1;
            end
            default:    rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/smbase_window_decode.sv
module smbase_window_decode #(
    parameter int          ADDR_W    = 32,
    parameter logic [63:0] WIN_BASE  = 64'h3_0000,
    parameter logic [63:0] WIN_BYTES = 64'h2_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] BASE_A = WIN_BASE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] SIZE_A = WIN_BYTES[ADDR_W-1:0];

    logic [ADDR_W-1:0] offset;

    assign offset = addr - BASE_A;
    assign hit    = (addr >= BASE_A) && (offset < SIZE_A);
endmodule

// File: rtl/smbase_lock_ctrl.sv
module smbase_lock_ctrl
    import smbase_lock_pkg::*;
#(
    parameter bit          FEATURE_EN = 1'b1,
    parameter int          ADDR_W     = 32,
    parameter logic [63:0] WIN_BASE   = 64'h3_0000,
    parameter logic [63:0] WIN_BYTES  = 64'h2_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wr_data,
    output logic [7:0]        reg_rd_data,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    output logic              route_blackhole,
    output logic              route_smram
);
    logic locked;
    logic win_hit;

    generate
        if (FEATURE_EN) begin : g_active
            smbase_lock_fsm #(
                .QUERY (QUERY_CODE),
                .ANSWER(ANSWER_CODE),
                .LOCK  (LOCK_CODE)
            ) fsm_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (reg_wr_en),
                .wr_data(reg_wr_data),
                .rd_data(reg_rd_data),
                .locked (locked)
            );
        end else begin : g_inert
            assign reg_rd_data = 8'h00;
            assign locked      = 1'b0;
        end
    endgenerate

    smbase_window_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_BYTES(WIN_BYTES)
    ) dec_i (
        .addr(acc_addr),
        .hit (win_hit)
    );

    assign route_blackhole = locked && win_hit && !acc_smm;
    assign route_smram     = locked && win_hit &&  acc_smm;
endmodule

// File: rtl/smbase_lock_chk.sv
module smbase_lock_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [7:0]        reg_wr_data,
    input logic [7:0]        reg_rd_data,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_smm,
    input logic              route_blackhole,
    input logic              route_smram
);
    // R6: a locked register never changes until reset
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data == 8'h02 |=> reg_rd_data == 8'h02);

    // R3: query from IDLE yields the capability code
    a_r3_query_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data == 8'h00 && reg_wr_en && reg_wr_data == 8'hFF && route_blackhole == 1'b0)
        |=> (reg_rd_data == 8'h01 || reg_rd_data == 8'h00));

    // R7: blackhole is only for non-management accesses
    a_r7_blackhole_nonsmm: assert property (@(posedge clk) disable iff (!rst_n)
        route_blackhole |-> !acc_smm);

    // R8: both routes are never raised together
    a_r8_routes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({route_blackhole, route_smram}) <= 1);

    // R9: routing needs the locked value
    a_r9_unlocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data != 8'h02 |-> !route_blackhole && !route_smram);

    // R2: a non-query write in IDLE keeps the register at zero
    a_r2_discard_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data == 8'h00 && reg_wr_en && reg_wr_data != 8'hFF) |=> reg_rd_data == 8'h00);
endmodule

bind smbase_lock_ctrl smbase_lock_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr_en      (reg_wr_en),
    .reg_wr_data    (reg_wr_data),
    .reg_rd_data    (reg_rd_data),
    .acc_addr       (acc_addr),
    .acc_smm        (acc_smm),
    .route_blackhole(route_blackhole),
    .route_smram    (route_smram)
);

// File: tb/smbase_lock_ctrl_tb.sv
`timescale 1ns/1ps
module smbase_lock_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_data = 8'h00;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_smm = 1'b0;
    logic [7:0]  rd_a, rd_b;
    logic        bh_a, sm_a, bh_b, sm_b;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural model state: value and write mask
    int m_val  = 0;
    int m_mask = 255;

    always #2 clk = ~clk;

    smbase_lock_ctrl #(.FEATURE_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(rd_a), .acc_addr(acc_addr), .acc_smm(acc_smm),
        .route_blackhole(bh_a), .route_smram(sm_a)
    );

    smbase_lock_ctrl #(.FEATURE_EN(1'b0)) dut_off_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(rd_b), .acc_addr(acc_addr), .acc_smm(acc_smm),
        .route_blackhole(bh_b), .route_smram(sm_b)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_val  = 0;
            m_mask = 255;
        end else if (reg_wr_en) begin
            int nv;
            nv = (m_val & ~m_mask & 255) | (int'(reg_wr_data) & m_mask);
            if (nv == 255) begin
                nv = 1;
                m_mask = 2;
            end else if (m_mask == 255) begin
                nv = 0;
            end
            if ((nv & 2) != 0) begin
                m_mask = m_mask & ~2;
                nv = 2;
            end
            m_val = nv;
        end
    end

    task automatic cmp(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // compare both instances on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit hit, lk;
            hit = (acc_addr >= 32'h3_0000) && (acc_addr < 32'h5_0000);
            lk  = (m_mask == 0);
            cmp("rd",       int'(rd_a), m_val);
            cmp("blackhole", int'(bh_a), int'(lk && hit && !acc_smm));
            cmp("smram",     int'(sm_a), int'(lk && hit && acc_smm));
            cmp("R10 rd_off", int'(rd_b), 0);
            cmp("R10 bh_off", int'(bh_b), 0);
            cmp("R10 sm_off", int'(sm_b), 0);
        end
    end

    task automatic wr(logic [7:0] d, string req);
        @(negedge clk);
        cur_req = req;
        reg_wr_en = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wr_data = 8'h00;
    endtask

    task automatic probe(logic [31:0] a, logic smm, string req);
        @(negedge clk);
        cur_req = req;
        acc_addr = a;
        acc_smm = smm;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        probe(32'h3_0000, 1'b0, "R1");
        wr(8'h02, "R2");
        wr(8'h5A, "R2");
        probe(32'h3_8000, 1'b0, "R9");
        wr(8'hFF, "R3");
        wr(8'h01, "R4");
        wr(8'h80, "R4");
        wr(8'hFD, "R4");
        probe(32'h4_FFFF, 1'b1, "R9");
        probe(32'h3_0000, 1'b0, "R9");
        wr(8'h06, "R5");
        wr(8'h00, "R6");
        wr(8'hFF, "R6");
        wr(8'h01, "R6");
        probe(32'h3_0000, 1'b0, "R7");
        probe(32'h4_FFFF, 1'b0, "R7");
        probe(32'h3_0000, 1'b1, "R8");
        probe(32'h4_FFFF, 1'b1, "R8");
        probe(32'h2_FFFF, 1'b0, "R9");
        probe(32'h5_0000, 1'b1, "R9");
        probe(32'h0000_0000, 1'b0, "R9");
        do_reset();
        probe(32'h3_0000, 1'b0, "R1");
        wr(8'hFF, "R3");
        wr(8'hFF, "R5");
        probe(32'h3_1234, 1'b0, "R7");
        probe(32'h3_1234, 1'b1, "R8");
        wr(8'h00, "R6");
        probe(32'h3_1234, 1'b0, "R6");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule